// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Counter

A shift counter of `STAGES` flip-flops whose top stage is inverted and fed back into the bottom stage. This makes the register walk through `2*STAGES` codes. From one code to the next exactly one bit changes, so the stage outputs can drive clock-like or sequencing logic without decode glitches. Each stage is also a square wave at `1/(2*STAGES)` of the enabled step rate.

A bare twisted ring has parasitic cycles, and a register that powers up or is upset into one of them would stay there. This block adds one correction term. When the top and bottom stages both read 0, the next code is forced to `0...01`. That breaks every parasitic loop and leaves the legal cycle unchanged. An optional decoder turns each legal code into one line of a one-of-`2*STAGES` output, using only two-input AND terms of neighbouring stages.

Top module: `johnson_counter_sc`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `q` takes the value of parameter `RESET_STATE` (default all zeros), whatever `en` is.
- R2: With `rst_n` high and `en` low, a clock edge leaves `q` unchanged.
- R3: With `en` high and `q` in the legal cycle, the next `q` is `q` shifted one place toward the top stage, with the inverted top stage entering at bit 0. For 4 stages the order is 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000, then back to 0000.
- R4: The legal cycle starting from all zeros holds `2*STAGES` distinct codes and returns to all zeros after exactly `2*STAGES` enabled edges.
- R5: Every enabled step inside the legal cycle changes exactly one bit of `q`.
- R6: Over one full legal cycle, every stage reads 1 in exactly `STAGES` of the `2*STAGES` codes.
- R7: With `en` high, whenever `q[STAGES-1]` and `q[0]` are both 0, the next `q` is 1 in bit 0 and 0 in every other bit.
- R8: From any illegal code, `q` reaches a legal code within `STAGES` enabled edges (checked exhaustively for 4 stages) and never leaves the legal cycle afterwards.
- R9: With `DECODE_EN` = 1 and `q` legal, `state_dec` is one-hot. Bit k is set for the k-th code of the R3 order, with all zeros as k = 0.
- R10: With `DECODE_EN` = 0, `state_dec` is constantly all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Step enable |
| q | output | STAGES | Stage vector, bit 0 is the entry stage |
| state_dec | output | 2*STAGES | One-hot index of the current legal code |

## Verification
The bench builds the main instance with 4 stages and the decoder enabled. It also builds sixteen further 4-stage instances with the decoder disabled, and gives each of them a different `RESET_STATE`, from 0 to 15. Reset therefore places these instances in every possible code, all eight illegal ones included. The bench can then follow each one back into the legal cycle through its ports, confirm the forced `0001` step, and watch the constant zero decode output.

// File: rtl/jc_pkg.sv
`timescale 1ns/1ps
package jc_pkg;

   // Which source the state register takes on the coming edge
   typedef enum logic [1:0] {
      JC_SRC_RESET = 2'd0,
      JC_SRC_HOLD  = 2'd1,
      JC_SRC_SHIFT = 2'd2,
      JC_SRC_FIX   = 2'd3
   } jc_src_e;

   function automatic int unsigned jc_code_count(int unsigned stages);
      return 2 * stages;
   endfunction

endpackage

// File: rtl/jc_next_state.sv
`timescale 1ns/1ps
module jc_next_state
   import jc_pkg::*;
#(
   parameter int unsigned STAGES = 4
) (
   input  logic              rst_n,
   input  logic              en,
   input  logic [STAGES-1:0] cur,
   output jc_src_e           src,
   output logic [STAGES-1:0] nxt
);

   localparam logic [STAGES-1:0] FIX_CODE = {{(STAGES-1){1'b0}}, 1'b1};

   logic              ends_low;
   logic [STAGES-1:0] shifted;

   // both end stages at zero marks the only code set that needs repair
   assign ends_low = ~cur[STAGES-1] & ~cur[0];
   assign shifted  = {cur[STAGES-2:0], ~cur[STAGES-1]};
   assign nxt      = ends_low ? FIX_CODE : shifted;

   always_comb begin
      if (!rst_n)        src = JC_SRC_RESET;
      else if (!en)      src = JC_SRC_HOLD;
      else if (ends_low) src = JC_SRC_FIX;
      else               src = JC_SRC_SHIFT;
   end

endmodule

// File: rtl/jc_state_reg.sv
`timescale 1ns/1ps
module jc_state_reg
   import jc_pkg::*;
#(
   parameter int unsigned       STAGES      = 4,
   parameter logic [STAGES-1:0] RESET_STATE = '0
) (
   input  logic              clk,
   input  jc_src_e           src,
   input  logic [STAGES-1:0] nxt,
   output logic [STAGES-1:0] cur
);

   always_ff @(posedge clk) begin
      unique case (src)
         JC_SRC_RESET: cur <= RESET_STATE;
         JC_SRC_HOLD:  cur <= cur;
         default:      cur <= nxt;
      endcase
   end

endmodule

// File: rtl/jc_decode.sv
`timescale 1ns/1ps
module jc_decode #(
   parameter int unsigned STAGES = 4,
   localparam int unsigned CODES = 2 * STAGES
) (
   input  logic [STAGES-1:0] cur,
   output logic [CODES-1:0]  dec
);

   // each legal code is named by the one place its bit pattern turns over
   for (genvar k = 0; k < CODES; k++) begin : g_term
      if (k == 0) begin : g_zero
         assign dec[k] = ~cur[STAGES-1] & ~cur[0];
      end else if (k < STAGES) begin : g_fill
         assign dec[k] = cur[k-1] & ~cur[k];
      end else if (k == STAGES) begin : g_full
         assign dec[k] = cur[STAGES-1] & cur[0];
      end else begin : g_drain
         assign dec[k] = ~cur[k-STAGES-1] & cur[k-STAGES];
      end
   end

endmodule

// File: rtl/johnson_counter_sc.sv
`timescale 1ns/1ps
module johnson_counter_sc
   import jc_pkg::*;
#(
   parameter int unsigned       STAGES      = 4,
   parameter logic [STAGES-1:0] RESET_STATE = '0,
   parameter bit                DECODE_EN   = 1'b1,
   localparam int unsigned      CODES       = jc_code_count(STAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   output logic [STAGES-1:0] q,
   output logic [CODES-1:0]  state_dec
);

   if (STAGES < 2) begin : g_bad_stages
      $error("johnson_counter_sc: STAGES must be at least 2");
   end
   if (CODES != 2 * STAGES) begin : g_bad_codes
      $error("johnson_counter_sc: code count mismatch");
   end

   jc_src_e           src;
   logic [STAGES-1:0] nxt;

   jc_next_state #(.STAGES(STAGES)) u_next (
      .rst_n (rst_n),
      .en    (en),
      .cur   (q),
      .src   (src),
      .nxt   (nxt)
   );

   jc_state_reg #(.STAGES(STAGES), .RESET_STATE(RESET_STATE)) u_reg (
      .clk (clk),
      .src (src),
      .nxt (nxt),
      .cur (q)
   );

   if (DECODE_EN) begin : g_dec
      jc_decode #(.STAGES(STAGES)) u_dec (
         .cur (q),
         .dec (state_dec)
      );
   end else begin : g_nodec
      assign state_dec = '0;
   end

endmodule

// File: rtl/jc_checker.sv
`timescale 1ns/1ps
module jc_checker #(
   parameter int unsigned STAGES    = 4,
   parameter bit          DECODE_EN = 1'b1,
   localparam int unsigned CODES    = 2 * STAGES,
   localparam int unsigned LIMIT    = 2 * STAGES,
   localparam int unsigned CW       = $clog2(LIMIT + 2)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [STAGES-1:0] q,
   input logic [CODES-1:0]  state_dec
);

   // legal codes are a single run of ones against a single run of zeros
   function automatic bit is_legal(logic [STAGES-1:0] v);
      int unsigned edges = 0;
      for (int i = 0; i < STAGES - 1; i++) if (v[i] != v[i+1]) edges++;
      return edges <= 1;
   endfunction

   logic          legal;
   logic [CW-1:0] bad_cnt;

   assign legal = is_legal(q);

   always_ff @(posedge clk) begin
      if (!rst_n)                          bad_cnt <= '0;
      else if (legal)                      bad_cnt <= '0;
      else if (en && bad_cnt <= CW'(LIMIT)) bad_cnt <= bad_cnt + 1'b1;
   end

   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(q));

   a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (en && legal) |=> q == {$past(q[STAGES-2:0]), ~$past(q[STAGES-1])});

   a_r5_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (en && legal) |=> $countones(q ^ $past(q)) == 1);

   a_r7_fix: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !q[STAGES-1] && !q[0]) |=> q == {{(STAGES-1){1'b0}}, 1'b1});

   a_r8_stay_legal: assert property (@(posedge clk) disable iff (!rst_n)
      legal |=> legal);

   a_r8_recover_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bad_cnt <= CW'(LIMIT));

   a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      (DECODE_EN && legal) |-> $countones(state_dec) == 1);

   a_r10_dec_off: assert property (@(posedge clk) disable iff (!rst_n)
      !DECODE_EN |-> state_dec == '0);

endmodule

bind johnson_counter_sc jc_checker #(.STAGES(STAGES), .DECODE_EN(DECODE_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .en        (en),
   .q         (q),
   .state_dec (state_dec)
);

// File: tb/test_johnson_counter_sc.sv
`timescale 1ns/1ps
module test_johnson_counter_sc;

   localparam int N = 4;
   localparam int C = 2 * N;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic [N-1:0] q;
   logic [C-1:0] state_dec;
   int           checks = 0;
   int           fails = 0;
   bit           done = 1'b0;

   always #2.5 clk = ~clk;

   johnson_counter_sc #(.STAGES(N)) i_johnson_counter_sc (
      .clk(clk), .rst_n(rst_n), .en(en), .q(q), .state_dec(state_dec)
   );

   logic [N-1:0] rq [16];
   logic [C-1:0] rd [16];
   for (genvar g = 0; g < 16; g++) begin : g_rec
      johnson_counter_sc #(.STAGES(N), .RESET_STATE(4'(g)), .DECODE_EN(1'b0)) u_rec (
         .clk(clk), .rst_n(rst_n), .en(en), .q(rq[g]), .state_dec(rd[g])
      );
   end

   // {en, expected q, expected state_dec} after each edge, starting from 0000
   localparam logic [12:0] VEC [16] = '{
      {1'b1, 4'b0001, 8'h02}, {1'b1, 4'b0011, 8'h04}, {1'b0, 4'b0011, 8'h04},
      {1'b1, 4'b0111, 8'h08}, {1'b1, 4'b1111, 8'h10}, {1'b0, 4'b1111, 8'h10},
      {1'b0, 4'b1111, 8'h10}, {1'b1, 4'b1110, 8'h20}, {1'b1, 4'b1100, 8'h40},
      {1'b1, 4'b1000, 8'h80}, {1'b1, 4'b0000, 8'h01}, {1'b1, 4'b0001, 8'h02},
      {1'b1, 4'b0011, 8'h04}, {1'b1, 4'b0111, 8'h08}, {1'b1, 4'b1111, 8'h10},
      {1'b1, 4'b1110, 8'h20}
   };

   localparam logic [N-1:0] LEGAL [C] = '{
      4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111, 4'b1110, 4'b1100, 4'b1000
   };

   function automatic bit in_cycle(logic [N-1:0] v);
      for (int i = 0; i < C; i++) if (v === LEGAL[i]) return 1'b1;
      return 1'b0;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic [N-1:0] seq [C+1];
      bit           seen [16];
      int           ones;

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check(q === 4'b0000, "R1 reset q", q, 0);
      check(state_dec === 8'h01, "R9 reset dec", state_dec, 8'h01);

      // R2 R3 R9 table walk
      @(negedge clk) rst_n = 1'b1;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk) en = VEC[i][12];
         @(posedge clk);
         #1;
         check(q === VEC[i][11:8], "R3/R2 q", q, VEC[i][11:8]);
         check(state_dec === VEC[i][7:0], "R9 dec", state_dec, VEC[i][7:0]);
      end

      // R1: reset wins over enable mid-cycle
      @(negedge clk) begin rst_n = 1'b0; en = 1'b1; end
      @(posedge clk);
      #1;
      check(q === 4'b0000, "R1 reset with en", q, 0);

      // R4 R5 R6: one full cycle
      seq[0] = q;
      @(negedge clk) rst_n = 1'b1;
      for (int s = 1; s <= C; s++) begin
         @(posedge clk);
         #1;
         seq[s] = q;
         check($countones(seq[s] ^ seq[s-1]) == 1, "R5 one bit step", seq[s], seq[s-1]);
      end
      check(seq[C] === 4'b0000, "R4 return to zero", seq[C], 0);
      for (int s = 1; s < C; s++)
         check(seq[s] !== 4'b0000, "R4 distinct", seq[s], 1);
      for (int b = 0; b < N; b++) begin
         ones = 0;
         for (int s = 0; s < C; s++) ones += seq[s][b];
         check(ones == N, "R6 duty", ones, N);
      end

      // R1 R7 R8 R10: every starting code via reset pattern
      @(negedge clk) begin rst_n = 1'b0; en = 1'b1; end
      @(posedge clk);
      #1;
      for (int g = 0; g < 16; g++) begin
         check(rq[g] === 4'(g), "R1 reset pattern", rq[g], g);
         seen[g] = in_cycle(rq[g]);
      end
      @(negedge clk) rst_n = 1'b1;
      for (int c = 1; c <= 12; c++) begin
         @(posedge clk);
         #1;
         for (int g = 0; g < 16; g++) begin
            if (c == 1 && g[3] == 1'b0 && g[0] == 1'b0)
               check(rq[g] === 4'b0001, "R7 forced 0001", rq[g], 1);
            if (in_cycle(rq[g])) seen[g] = 1'b1;
            else check(!seen[g], "R8 left cycle", rq[g], g);
            if (c == N) check(seen[g], "R8 recovery bound", rq[g], g);
            if (c == 12) check(rd[g] === '0, "R10 decode off", rd[g], 0);
         end
      end

      finish_run();
   end

endmodule